// File: doc/BRIEF.md
# Pin Sequencing Instruction Executor

This block runs a stored list of 32-bit instructions, one at a time, to drive a bank of general-purpose pins. For each pin it holds an output level and an output-enable bit, and it watches the pin inputs, which arrive already synchronized. Instructions can set, clear, release or flip the direction of one pin or of a masked group of pins. They can also wait for a number of divider ticks, stall until a pin reaches a level, hand a sampling job to an external read-capture unit, or repeat the program.

The instruction pointer and the program store are outside this block. The executor sees the word at the current pointer and a flag that says whether that word is valid. It answers with a step request, which moves the pointer forward by one, or a rewind request, which sends the pointer back to slot zero. Both requests are combinational and are sampled at the next rising clock edge. A loop-finished event pulses in the same cycle as the step that leaves a counted loop. Software can set a stop-at-loop input so that an endless program leaves its loop cleanly.

Top module: `pinseq_exec`

## Requirements
- R1: After reset, all pin levels and output enables are 0, and no step, rewind, loop-done or read-start output is asserted.
- R2: An instruction holds the command in bits 3:0, the pin index in the next PIN_W bits and the data in the remaining upper bits. Code 0x0 drives the selected pin high and code 0x2 drives it low, setting its enable to 1 in both cases. Either one requests a step in the same cycle it is decoded.
- R3: Code 0x4 clears the selected pin's enable. Code 0x6 inverts that enable and leaves the pin level unchanged. Both step at once.
- R4: Codes 0x1 (drive high), 0x3 (drive low), 0x5 (release) and 0x7 (flip direction) apply to every pin i whose data bit i is 1. They leave the other pins unchanged and step at once.
- R5: Code 0x8 with data D>0 steps exactly D*(V+1) cycles after its decode cycle, where V is the divider value. With D=0 it steps in the decode cycle.
- R6: Code 0x9 steps in the first cycle in which the selected input is 1. Code 0xA steps in the first cycle in which that input is 0.
- R7: Code 0xB clears the selected pin's enable and pulses read-start for one cycle with the pin index. It then steps in the first later cycle in which read-done is 1.
- R8: Code 0xC with data 0 always requests a rewind, unless stop-at-loop is set.
- R9: Code 0xC with data N>0 rewinds N-1 times. On its N-th pass it clears the loop count, steps and pulses loop-done.
- R10: While stop-at-loop is 1, every 0xC steps, pulses no loop-done and clears the loop count.
- R11: Codes 0xD, 0xE and 0xF change no pin and step at once.
- R12: While enable is 0, or while the word is not valid in the run state, no request is issued and the pins hold. A rising edge of enable cancels any wait and clears the loop count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Run enable; a rising edge restarts the loop count |
| stop_at_loop | input | 1 | Forces every loop instruction to step past |
| div_val | input | DIV_W | Divider value V; one tick every V+1 cycles |
| prog_valid | input | 1 | The word at the current pointer is valid |
| instr | input | 32 | Instruction word at the current pointer |
| pin_in | input | N_PINS | Synchronized pin inputs |
| rd_done | input | 1 | Completion from the read-capture unit |
| pin_out | output | N_PINS | Driven pin levels |
| pin_oe | output | N_PINS | Pin output enables |
| step_req | output | 1 | Advance the pointer by one |
| rewind_req | output | 1 | Set the pointer to zero |
| loop_done | output | 1 | Counted loop finished |
| rd_start | output | 1 | Start a read on rd_pin |
| rd_pin | output | PIN_W | Pin index for the read |

## Verification
The hardest situation to reach is a counted loop that is cut short. This covers a program re-enabled partway through its repeats, where the stale loop count must vanish, and a loop reached while stop-at-loop toggles. The random phase therefore runs many short programs that end in loops with small counts. Between programs it lowers and raises enable at random, and it toggles stop-at-loop on some cycles. A cycle-level reference in the bench tracks the expected loop count across these restarts. Directed runs also stop an endless loop and pause a wait midway.

// File: rtl/pinseq_pkg.sv
package pinseq_pkg;

   localparam logic [3:0] OP_HIGH       = 4'h0;
   localparam logic [3:0] OP_HIGH_SET   = 4'h1;
   localparam logic [3:0] OP_LOW        = 4'h2;
   localparam logic [3:0] OP_LOW_SET    = 4'h3;
   localparam logic [3:0] OP_FLOAT      = 4'h4;
   localparam logic [3:0] OP_FLOAT_SET  = 4'h5;
   localparam logic [3:0] OP_TOGGLE     = 4'h6;
   localparam logic [3:0] OP_TOGGLE_SET = 4'h7;
   localparam logic [3:0] OP_WAIT       = 4'h8;
   localparam logic [3:0] OP_WAIT_HI    = 4'h9;
   localparam logic [3:0] OP_WAIT_LO    = 4'hA;
   localparam logic [3:0] OP_READ       = 4'hB;
   localparam logic [3:0] OP_LOOP       = 4'hC;

   typedef enum logic [2:0] {
      PA_NONE,
      PA_DRIVE_HI,
      PA_DRIVE_LO,
      PA_RELEASE,
      PA_FLIP_DIR
   } pin_act_e;

   typedef enum logic [1:0] {
      ST_RUN,
      ST_TIMED,
      ST_READ
   } exec_st_e;

endpackage

// File: rtl/pinseq_pin_bank.sv
module pinseq_pin_bank
   import pinseq_pkg::*;
#(
   parameter int N_PINS = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  pin_act_e          act,
   input  logic [N_PINS-1:0] sel,
   output logic [N_PINS-1:0] out,
   output logic [N_PINS-1:0] oe
);

   for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      logic out_q, oe_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            out_q <= 1'b0;
            oe_q  <= 1'b0;
         end else if (sel[i]) begin
            case (act)
               PA_DRIVE_HI: begin out_q <= 1'b1; oe_q <= 1'b1; end
               PA_DRIVE_LO: begin out_q <= 1'b0; oe_q <= 1'b1; end
               PA_RELEASE:  oe_q <= 1'b0;
               PA_FLIP_DIR: oe_q <= ~oe_q;
               default: ;
            endcase
         end
      end

      assign out[i] = out_q;
      assign oe[i]  = oe_q;

      // R3: a released pin has its enable low in the next cycle
      p_release_drops_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (act == PA_RELEASE && sel[i]) |=> !oe[i]);
      // R3: flipping direction never changes the level
      p_flip_keeps_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (act == PA_FLIP_DIR && sel[i]) |=> $stable(out[i]));
      // R4: an unselected pin holds its state
      p_unselected_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !sel[i] |=> ($stable(out[i]) && $stable(oe[i])));
   end

endmodule

// File: rtl/pinseq_tick_timer.sv
module pinseq_tick_timer #(
   parameter int CNT_W = 24,
   parameter int DIV_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic [CNT_W-1:0] count,
   input  logic [DIV_W-1:0] div_val,
   output logic             expire
);

   logic [DIV_W-1:0] div_cnt;
   logic [CNT_W-1:0] remaining;
   logic             running;
   logic             tick;

   assign tick   = running && (div_cnt == div_val);
   assign expire = tick && (remaining == CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_cnt   <= '0;
         remaining <= '0;
         running   <= 1'b0;
      end else if (abort) begin
         running   <= 1'b0;
         div_cnt   <= '0;
      end else if (start) begin
         running   <= 1'b1;
         remaining <= count;
         div_cnt   <= '0;
      end else if (running) begin
         if (tick) begin
            div_cnt   <= '0;
            remaining <= remaining - CNT_W'(1);
            if (remaining == CNT_W'(1)) running <= 1'b0;
         end else begin
            div_cnt <= div_cnt + DIV_W'(1);
         end
      end
   end

   // R5: a timed wait is never started with a zero count
   p_start_nonzero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      start |-> (count != '0));
   // R5: while counting, ticks remain outstanding
   p_busy_has_ticks_r5: assert property (@(posedge clk) disable iff (!rst_n)
      running |-> (remaining != '0));
   // R5: expiry ends the wait
   p_expire_stops_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !start && !abort) |=> !running);

endmodule

// File: rtl/pinseq_loop_ctr.sv
module pinseq_loop_ctr #(
   parameter int W = 24
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         bump,
   input  logic [W-1:0] limit,
   output logic [W-1:0] count,
   output logic         at_last
);

   localparam int XW = W + 1;

   assign at_last = ({1'b0, count} + XW'(1)) >= {1'b0, limit};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     count <= '0;
      else if (clear) count <= '0;
      else if (bump)  count <= count + W'(1);
   end

   // R9: a repeat is only counted while the limit is not yet reached
   p_bump_below_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bump && !clear) |=> (count != '0));

endmodule

// File: rtl/pinseq_exec.sv
module pinseq_exec
   import pinseq_pkg::*;
#(
   parameter int N_PINS = 16,
   parameter int DIV_W  = 20,
   parameter int PIN_W  = $clog2(N_PINS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              stop_at_loop,
   input  logic [DIV_W-1:0]  div_val,
   input  logic              prog_valid,
   input  logic [31:0]       instr,
   input  logic [N_PINS-1:0] pin_in,
   input  logic              rd_done,
   output logic [N_PINS-1:0] pin_out,
   output logic [N_PINS-1:0] pin_oe,
   output logic              step_req,
   output logic              rewind_req,
   output logic              loop_done,
   output logic              rd_start,
   output logic [PIN_W-1:0]  rd_pin
);

   localparam int CMD_W  = 4;
   localparam int DATA_W = 32 - CMD_W - PIN_W;
   localparam int DATA_LO = CMD_W + PIN_W;

   if (N_PINS < 2) begin : g_bad_pins
      $error("pinseq_exec: N_PINS must be at least 2");
   end
   if (PIN_W != $clog2(N_PINS)) begin : g_bad_pinw
      $error("pinseq_exec: PIN_W must equal clog2(N_PINS)");
   end
   if (N_PINS > DATA_W) begin : g_bad_mask
      $error("pinseq_exec: pin mask does not fit the data field");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("pinseq_exec: DIV_W must be positive");
   end

   exec_st_e           state;
   logic               en_q;
   logic               en_rise;
   logic [3:0]         cmd;
   logic [PIN_W-1:0]   pin;
   logic [DATA_W-1:0]  data;
   logic               decode;
   logic [N_PINS-1:0]  one_hot;
   logic [N_PINS-1:0]  mask;
   pin_act_e           act;
   logic [N_PINS-1:0]  sel;
   logic               tmr_start;
   logic               tmr_expire;
   logic               lp_clear;
   logic               lp_bump;
   logic               lp_last;
   logic [DATA_W-1:0]  lp_count;
   logic               goto_timed;
   logic               goto_read;

   assign cmd     = instr[CMD_W-1:0];
   assign pin     = instr[CMD_W +: PIN_W];
   assign data    = instr[31:DATA_LO];
   assign one_hot = N_PINS'(1) << pin;
   assign mask    = data[N_PINS-1:0];
   assign decode  = enable && prog_valid && (state == ST_RUN);
   assign en_rise = enable && !en_q;
   assign rd_pin  = pin;

   always_comb begin
      act        = PA_NONE;
      sel        = '0;
      step_req   = 1'b0;
      rewind_req = 1'b0;
      loop_done  = 1'b0;
      rd_start   = 1'b0;
      tmr_start  = 1'b0;
      lp_bump    = 1'b0;
      lp_clear   = en_rise;
      goto_timed = 1'b0;
      goto_read  = 1'b0;
      if (decode) begin
         case (cmd)
            OP_HIGH:       begin act = PA_DRIVE_HI; sel = one_hot; step_req = 1'b1; end
            OP_LOW:        begin act = PA_DRIVE_LO; sel = one_hot; step_req = 1'b1; end
            OP_FLOAT:      begin act = PA_RELEASE;  sel = one_hot; step_req = 1'b1; end
            OP_TOGGLE:     begin act = PA_FLIP_DIR; sel = one_hot; step_req = 1'b1; end
            OP_HIGH_SET:   begin act = PA_DRIVE_HI; sel = mask;    step_req = 1'b1; end
            OP_LOW_SET:    begin act = PA_DRIVE_LO; sel = mask;    step_req = 1'b1; end
            OP_FLOAT_SET:  begin act = PA_RELEASE;  sel = mask;    step_req = 1'b1; end
            OP_TOGGLE_SET: begin act = PA_FLIP_DIR; sel = mask;    step_req = 1'b1; end
            OP_WAIT: begin
               if (data == '0) step_req = 1'b1;
               else begin
                  tmr_start  = 1'b1;
                  goto_timed = 1'b1;
               end
            end
            OP_WAIT_HI: step_req = pin_in[pin];
            OP_WAIT_LO: step_req = !pin_in[pin];
            OP_READ: begin
               act       = PA_RELEASE;
               sel       = one_hot;
               rd_start  = 1'b1;
               goto_read = 1'b1;
            end
            OP_LOOP: begin
               if (stop_at_loop) begin
                  step_req = 1'b1;
                  lp_clear = 1'b1;
               end else if (data == '0) begin
                  rewind_req = 1'b1;
               end else if (lp_last) begin
                  step_req  = 1'b1;
                  loop_done = 1'b1;
                  lp_clear  = 1'b1;
               end else begin
                  rewind_req = 1'b1;
                  lp_bump    = 1'b1;
               end
            end
            default: step_req = 1'b1;
         endcase
      end else if (enable && state == ST_TIMED) begin
         step_req = tmr_expire;
      end else if (enable && state == ST_READ) begin
         step_req = rd_done;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_RUN;
         en_q  <= 1'b0;
      end else begin
         en_q <= enable;
         if (!enable) state <= ST_RUN;
         else begin
            case (state)
               ST_RUN: begin
                  if (goto_timed)     state <= ST_TIMED;
                  else if (goto_read) state <= ST_READ;
               end
               ST_TIMED: if (tmr_expire) state <= ST_RUN;
               ST_READ:  if (rd_done)    state <= ST_RUN;
               default:  state <= ST_RUN;
            endcase
         end
      end
   end

   pinseq_pin_bank #(.N_PINS(N_PINS)) u_pins (
      .clk   (clk),
      .rst_n (rst_n),
      .act   (act),
      .sel   (sel),
      .out   (pin_out),
      .oe    (pin_oe)
   );

   pinseq_tick_timer #(.CNT_W(DATA_W), .DIV_W(DIV_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (tmr_start),
      .abort   (!enable),
      .count   (data),
      .div_val (div_val),
      .expire  (tmr_expire)
   );

   pinseq_loop_ctr #(.W(DATA_W)) u_loop (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear   (lp_clear),
      .bump    (lp_bump),
      .limit   (data),
      .count   (lp_count),
      .at_last (lp_last)
   );

   // R8: the pointer is never asked to step and rewind together
   p_one_request_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(step_req && rewind_req));
   // R9: loop completion coincides with a step
   p_done_with_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
      loop_done |-> (step_req && !rewind_req));
   // R9: leaving a counted loop leaves the count at zero
   p_done_clears_count_r9: assert property (@(posedge clk) disable iff (!rst_n)
      loop_done |=> (lp_count == '0));
   // R10: the stop override never reports completion
   p_stop_no_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
      stop_at_loop |-> !loop_done);
   // R7: after a read is launched, a step only follows a completion
   p_read_waits_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start && enable) |=> (!enable || (step_req == rd_done)));
   // R12: a disabled executor issues nothing
   p_idle_when_off_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !(step_req || rewind_req || rd_start || loop_done));

endmodule

// File: tb/pinseq_exec_test.sv
module pinseq_exec_test;
   localparam int N  = 16;
   localparam int PW = 4;
   localparam int VW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          enable = 1'b0;
   logic          stop_at_loop = 1'b0;
   logic [VW-1:0] div_val = '0;
   logic [N-1:0]  pin_in = '0;
   logic          rd_done = 1'b0;
   logic          restart = 1'b0;
   logic          run_check = 1'b0;
   logic [31:0]   prog [16];
   int            len = 0;
   int            ptr = 0;
   logic          prog_valid;
   logic [31:0]   instr;
   logic [N-1:0]  pin_out, pin_oe;
   logic          step_req, rewind_req, loop_done, rd_start;
   logic [PW-1:0] rd_pin;

   int n_cmp = 0;
   int n_bad = 0;
   int n_done_seen = 0;

   logic [N-1:0] m_out = '0, m_oe = '0;
   int           m_age = 0;
   int           m_cnt = 0;

   always #4 clk = ~clk;

   assign prog_valid = (ptr < len) && !restart;
   assign instr      = (ptr < len) ? prog[ptr[3:0]] : 32'h0;

   pinseq_exec uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .stop_at_loop(stop_at_loop),
      .div_val(div_val), .prog_valid(prog_valid), .instr(instr), .pin_in(pin_in),
      .rd_done(rd_done), .pin_out(pin_out), .pin_oe(pin_oe), .step_req(step_req),
      .rewind_req(rewind_req), .loop_done(loop_done), .rd_start(rd_start), .rd_pin(rd_pin)
   );

   always @(posedge clk) begin
      if (!rst_n || restart) ptr <= 0;
      else if (rewind_req)   ptr <= 0;
      else if (step_req)     ptr <= ptr + 1;
   end

   function automatic logic [31:0] mk(input logic [3:0] c, input int p, input int d);
      return {d[23:0], p[3:0], c};
   endfunction

   function automatic string tag_of(input logic [3:0] c);
      case (c)
         4'h0, 4'h2: return "R2";
         4'h4, 4'h6: return "R3";
         4'h1, 4'h3, 4'h5, 4'h7: return "R4";
         4'h8: return "R5";
         4'h9, 4'hA: return "R6";
         4'hB: return "R7";
         4'hC: return "R8/R9/R10";
         default: return "R11";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
      end
   endtask

   // cycle-level reference built from the requirements
   always @(negedge clk) begin
      #1;
      if (rst_n && run_check) begin
         logic [3:0]  c;
         int          p, d;
         logic        e_step, e_rew, e_done, e_rd;
         logic [N-1:0] sel;
         string       t;
         e_step = 0; e_rew = 0; e_done = 0; e_rd = 0;
         c = instr[3:0]; p = int'(instr[7:4]); d = int'(instr[31:8]);
         t = enable ? tag_of(c) : "R12";
         chk("R2/R3/R4/R7 pin level", pin_out, m_out);
         chk("R2/R3/R4/R7 pin enable", pin_oe, m_oe);
         if (restart) m_cnt = 0;
         if (!enable) begin
            m_age = 0;
         end else if (prog_valid || m_age > 0) begin
            sel = (c[0] && c < 4'h8) ? instr[8 +: N] : (N'(1) << p);
            case (c)
               4'h0, 4'h1: if (m_age == 0) begin m_out |= sel; m_oe |= sel; e_step = 1; end
               4'h2, 4'h3: if (m_age == 0) begin m_out &= ~sel; m_oe |= sel; e_step = 1; end
               4'h4, 4'h5: if (m_age == 0) begin m_oe &= ~sel; e_step = 1; end
               4'h6, 4'h7: if (m_age == 0) begin m_oe ^= sel; e_step = 1; end
               4'h8: e_step = (d == 0) ? (m_age == 0) : (m_age == d * (int'(div_val) + 1));
               4'h9: e_step = pin_in[p];
               4'hA: e_step = !pin_in[p];
               4'hB: begin
                  if (m_age == 0) begin e_rd = 1; m_oe &= ~sel; end
                  else e_step = rd_done;
               end
               4'hC: begin
                  if (stop_at_loop) begin e_step = 1; m_cnt = 0; end
                  else if (d == 0) e_rew = 1;
                  else if (m_cnt + 1 >= d) begin e_step = 1; e_done = 1; m_cnt = 0; end
                  else begin e_rew = 1; m_cnt++; end
               end
               default: e_step = 1;
            endcase
            m_age = (e_step || e_rew) ? 0 : m_age + 1;
         end
         chk({t, " step"}, step_req, e_step);
         chk({t, " rewind"}, rewind_req, e_rew);
         chk({t, " loop done"}, loop_done, e_done);
         chk({t, " read start"}, rd_start, e_rd);
         if (e_rd) chk("R7 read pin", rd_pin, p[PW-1:0]);
         if (loop_done) n_done_seen++;
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic start_run;
      @(negedge clk);
      restart = 1'b1;
      enable  = 1'b1;
      @(negedge clk);
      restart = 1'b0;
   endtask

   task automatic stop_run;
      @(negedge clk);
      enable = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      #(8 * 200000);
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'h5eed_1234));
      for (int i = 0; i < 16; i++) prog[i] = 32'h0;
      cycles(3);
      rst_n = 1'b1;
      cycles(1);
      // R1 reset state
      chk("R1 pin level", pin_out, '0);
      chk("R1 pin enable", pin_oe, '0);
      chk("R1 requests", {step_req, rewind_req, loop_done, rd_start}, 4'b0);
      run_check = 1'b1;

      // directed: single-pin, set, wait, counted loop of 3
      div_val = 2;
      prog[0] = mk(4'h0, 0, 0);
      prog[1] = mk(4'h8, 0, 3);
      prog[2] = mk(4'h2, 0, 0);
      prog[3] = mk(4'h6, 3, 0);
      prog[4] = mk(4'h1, 0, 24'h00F0);
      prog[5] = mk(4'h4, 5, 0);
      prog[6] = mk(4'hD, 0, 0);
      prog[7] = mk(4'hC, 0, 3);
      len = 8;
      n_done_seen = 0;
      start_run();
      cycles(120);
      chk("R9 pointer past loop", ptr, 8);
      chk("R9 single completion", n_done_seen, 1);
      stop_run();

      // directed: endless loop, then stop-at-loop
      prog[0] = mk(4'h7, 0, 24'h0003);
      prog[1] = mk(4'h8, 0, 1);
      prog[2] = mk(4'hC, 0, 0);
      len = 3;
      n_done_seen = 0;
      start_run();
      cycles(60);
      chk("R8 still looping", ptr < 3, 1);
      stop_at_loop = 1'b1;
      cycles(20);
      chk("R10 stopped past loop", ptr, 3);
      chk("R10 no completion", n_done_seen, 0);
      stop_at_loop = 1'b0;
      stop_run();

      // directed: disable during a wait holds pointer and pins
      prog[0] = mk(4'h0, 2, 0);
      prog[1] = mk(4'h8, 0, 50);
      prog[2] = mk(4'h0, 9, 0);
      len = 3;
      start_run();
      cycles(10);
      enable = 1'b0;
      cycles(20);
      chk("R12 pointer held", ptr, 1);
      chk("R12 pin unchanged", pin_oe[9], 1'b0);
      start_run();
      cycles(20);
      stop_run();

      // random programs
      for (int k = 0; k < 40; k++) begin
         len = 2 + ($urandom % 14);
         div_val = VW'($urandom % 3);
         for (int i = 0; i < 16; i++) begin
            logic [3:0] c;
            int d;
            c = 4'($urandom % 16);
            d = $urandom;
            if (c == 4'h8 || c == 4'hC) d = $urandom % 4;
            prog[i] = mk(c, $urandom % N, d);
         end
         if ($urandom % 2) prog[len - 1] = mk(4'hC, 0, 1 + $urandom % 3);
         start_run();
         for (int cyc = 0; cyc < 300; cyc++) begin
            pin_in = N'($urandom);
            rd_done = ($urandom % 3) == 0;
            stop_at_loop = ($urandom % 40) == 0;
            if (cyc == 150 && ($urandom % 3) == 0) begin
               enable = 1'b0;
               @(negedge clk);
               restart = 1'b1;
               enable = 1'b1;
            end
            @(negedge clk);
            restart = 1'b0;
         end
         stop_at_loop = 1'b0;
         stop_run();
      end

      run_check = 1'b0;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule